// File: doc/BRIEF.md
# External Interrupt Halt-and-Drain Controller

This block sits at the retirement point of a simple in-order core. It decides when a level-sensitive external interrupt request may be accepted, and it runs the halt sequence that comes before the jump to the handler. An accepted request does not redirect the core at once. The controller lets one more instruction retire, then holds back all later retirements and waits for the store queue to empty. Only then does it raise a one-cycle take pulse with the interrupt's vector. An instruction-fetch fault that appears at any point in this sequence wins. The fault is taken first. The interrupt must then be accepted again from the start.

Retirement uses a valid/ready style handshake. The core holds `cmpl_valid` high while an instruction is ready to retire. The instruction retires on a rising clock edge where `cmpl_valid` is high and `cmpl_block` is low. While `cmpl_block` is high, the core must keep the instruction and present it again later. The controller also keeps the external-enable bit itself. Software sets or clears the bit through a write strobe, and every take clears it.

Top module: `irq_halt_ctrl`

## Requirements
- R1: While `ee` is 0, a high `irq_req` has no effect. `cmpl_block` stays 0 and no take with cause 2'b10 occurs.
- R2: If `irq_req` arrives in an idle cycle together with a fetch fault, the fault is taken on the next cycle with cause 2'b01. The interrupt is not accepted in that cycle.
- R3: After the interrupt is accepted with `ee`=1, `cmpl_block` stays 0 until exactly one instruction has retired. It goes to 1 in the cycle after that retirement.
- R4: From that retirement until the take cycle, including the take cycle, `cmpl_block` is 1.
- R5: The interrupt is taken only after a cycle in which `stq_empty` is 1 while retirement is blocked. While `stq_empty` stays 0, the controller keeps waiting.
- R6: A fetch fault that arrives while the controller waits for the single retirement or for the drain is taken on the next cycle with cause 2'b01. The interrupt sequence is abandoned. The interrupt is accepted again only once `ee` is 1 again and `irq_req` is still high.
- R7: `vec_addr` is the base plus an offset. The base is 0x0000_0000 when `vsel`=0 and 0xFFF0_0000 when `vsel`=1. The offset is 0x500 for the external interrupt and 0x400 for a fetch fault.
- R8: A fetch fault exists when `ff_valid` is 1 and at least one of these holds: `ff_miss`, `ff_noexec`, `ff_prot`, or `ff_dseg` or `ff_guard` together with `xlate_on`=1. With `xlate_on`=0, `ff_dseg` and `ff_guard` raise nothing.
- R9: `take` is high for exactly one cycle. `cause` is 2'b01 for a fetch fault and 2'b10 for the external interrupt. Both `cause` and `vec_addr` are zero whenever `take` is 0.
- R10: Each take clears `ee` on the edge that ends the take cycle, and this clear wins over a software write in the same cycle. Otherwise `ee_wr` loads `ee_wdata` into `ee`. Reset sets `ee` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Level-sensitive external interrupt request |
| ee_wr | input | 1 | Software write strobe for the enable bit |
| ee_wdata | input | 1 | Value written to the enable bit |
| vsel | input | 1 | Vector base select |
| xlate_on | input | 1 | Instruction translation enabled |
| ff_valid | input | 1 | Fetch check result valid |
| ff_miss | input | 1 | Translation miss, no page entry found |
| ff_dseg | input | 1 | Fetch from a direct-store segment |
| ff_noexec | input | 1 | Fetch from no-execute memory |
| ff_guard | input | 1 | Fetch from guarded memory |
| ff_prot | input | 1 | Fetch protection violation |
| cmpl_valid | input | 1 | An instruction is ready to retire |
| stq_empty | input | 1 | No stores outstanding |
| cmpl_block | output | 1 | Retirement blocked (inverse of ready) |
| take | output | 1 | One-cycle exception take pulse |
| cause | output | 2 | Cause code during `take` |
| vec_addr | output | 32 | Handler address during `take` |
| ee | output | 1 | External-enable bit |

## Verification
Every decision is made on a rising edge, and its result is visible in the cycle after that edge. A fault or a stored-queue-empty condition sampled at edge N therefore shows up as `take` in the cycle after edge N. An acceptance at edge N lowers nothing, but a retirement in the allow cycle raises `cmpl_block` after the next edge. `ee` clears one edge after the take cycle. The bench drives its inputs shortly after each falling edge. A behavioural model advances on each rising edge, and all outputs are compared against it just after the following falling edge. Directed checks sample at those same points.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALLOW = 2'd1,
    ST_DRAIN = 2'd2,
    ST_TAKE  = 2'd3
  } irqh_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_FETCH = 2'b01,
    CAUSE_EXT   = 2'b10
  } irqh_cause_e;
endpackage

// File: rtl/irqh_fault_decode.sv
module irqh_fault_decode (
  input  logic ff_valid,
  input  logic xlate_on,
  input  logic ff_miss,
  input  logic ff_dseg,
  input  logic ff_noexec,
  input  logic ff_guard,
  input  logic ff_prot,
  output logic fault
);
  logic always_bad;
  logic xlate_bad;

  always_comb begin
    always_bad = ff_miss | ff_noexec | ff_prot;
    xlate_bad  = xlate_on & (ff_dseg | ff_guard);
    fault      = ff_valid & (always_bad | xlate_bad);
  end
endmodule

// File: rtl/irqh_seq.sv
module irqh_seq
  import irqh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_req,
  input  logic        fault,
  input  logic        cmpl_valid,
  input  logic        stq_empty,
  input  logic        ee_wr,
  input  logic        ee_wdata,
  output irqh_state_e st,
  output irqh_cause_e cause_q,
  output logic        ee_q
);
  irqh_state_e st_nxt;
  irqh_cause_e cause_nxt;
  logic        retire;

  always_comb begin
    st_nxt    = st;
    cause_nxt = cause_q;
    retire    = cmpl_valid;
    unique case (st)
      ST_IDLE: begin
        if (fault) begin
          st_nxt    = ST_TAKE;
          cause_nxt = CAUSE_FETCH;
        end else if (irq_req && ee_q) begin
          st_nxt = ST_ALLOW;
        end
      end
      ST_ALLOW: begin
        if (fault) begin
          st_nxt    = ST_TAKE;
          cause_nxt = CAUSE_FETCH;
        end else if (retire) begin
          st_nxt = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (fault) begin
          st_nxt    = ST_TAKE;
          cause_nxt = CAUSE_FETCH;
        end else if (stq_empty) begin
          st_nxt    = ST_TAKE;
          cause_nxt = CAUSE_EXT;
        end
      end
      ST_TAKE: begin
        st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cause_q <= CAUSE_NONE;
      ee_q    <= 1'b0;
    end else begin
      st      <= st_nxt;
      cause_q <= cause_nxt;
      if (st == ST_TAKE) begin
        ee_q <= 1'b0;
      end else if (ee_wr) begin
        ee_q <= ee_wdata;
      end
    end
  end
endmodule

// File: rtl/irqh_vector.sv
module irqh_vector
  import irqh_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] BASE_HI  = 32'hFFF0_0000,
  parameter logic [31:0] OFF_EXT  = 32'h0000_0500,
  parameter logic [31:0] OFF_FETCH = 32'h0000_0400
) (
  input  logic              active,
  input  logic              vsel,
  input  irqh_cause_e       cause_q,
  output logic [1:0]        cause,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam logic [ADDR_W-1:0] BASE_H = BASE_HI[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] O_EXT  = OFF_EXT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] O_FET  = OFF_FETCH[ADDR_W-1:0];

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off;

  always_comb begin
    base = vsel ? BASE_H : '0;
    off  = (cause_q == CAUSE_EXT) ? O_EXT : O_FET;
    if (active) begin
      cause    = cause_q;
      vec_addr = base + off;
    end else begin
      cause    = CAUSE_NONE;
      vec_addr = '0;
    end
  end
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
  import irqh_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              ee_wr,
  input  logic              ee_wdata,
  input  logic              vsel,
  input  logic              xlate_on,
  input  logic              ff_valid,
  input  logic              ff_miss,
  input  logic              ff_dseg,
  input  logic              ff_noexec,
  input  logic              ff_guard,
  input  logic              ff_prot,
  input  logic              cmpl_valid,
  input  logic              stq_empty,
  output logic              cmpl_block,
  output logic              take,
  output logic [1:0]        cause,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              ee
);
  logic        fault;
  irqh_state_e st;
  irqh_cause_e cause_q;

  irqh_fault_decode u_dec (
    .ff_valid (ff_valid),
    .xlate_on (xlate_on),
    .ff_miss  (ff_miss),
    .ff_dseg  (ff_dseg),
    .ff_noexec(ff_noexec),
    .ff_guard (ff_guard),
    .ff_prot  (ff_prot),
    .fault    (fault)
  );

  irqh_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .fault     (fault),
    .cmpl_valid(cmpl_valid),
    .stq_empty (stq_empty),
    .ee_wr     (ee_wr),
    .ee_wdata  (ee_wdata),
    .st        (st),
    .cause_q   (cause_q),
    .ee_q      (ee)
  );

  always_comb begin
    take       = (st == ST_TAKE);
    cmpl_block = (st == ST_DRAIN) || (st == ST_TAKE);
  end

  irqh_vector #(.ADDR_W(ADDR_W)) u_vec (
    .active  (take),
    .vsel    (vsel),
    .cause_q (cause_q),
    .cause   (cause),
    .vec_addr(vec_addr)
  );
endmodule

module irq_halt_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_req,
  input logic              ee,
  input logic              fault,
  input logic [1:0]        st,
  input logic              stq_empty,
  input logic              cmpl_block,
  input logic              take,
  input logic [1:0]        cause,
  input logic [ADDR_W-1:0] vec_addr
);
  a_r1_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !ee) |=> (st != 2'd1));
  a_r2_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && fault) |=> (take && cause == 2'b01));
  a_r4_block_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> cmpl_block);
  a_r5_drained_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !stq_empty && !fault) |=> !take);
  a_r6_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == 2'd1 || st == 2'd2) && fault) |=> (take && cause == 2'b01));
  a_r7_offset: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (vec_addr[11:0] == ((cause == 2'b10) ? 12'h500 : 12'h400)));
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  a_r10_ee_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ee);
endmodule

bind irq_halt_ctrl irq_halt_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .ee        (ee),
  .fault     (fault),
  .st        (st),
  .stq_empty (stq_empty),
  .cmpl_block(cmpl_block),
  .take      (take),
  .cause     (cause),
  .vec_addr  (vec_addr)
);

// File: tb/irq_halt_ctrl_bench.sv
`timescale 1ns/1ps
module irq_halt_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 0, ee_wr = 0, ee_wdata = 0, vsel = 0, xlate_on = 0;
  logic ff_valid = 0, ff_miss = 0, ff_dseg = 0, ff_noexec = 0, ff_guard = 0, ff_prot = 0;
  logic cmpl_valid = 0, stq_empty = 0;
  logic cmpl_block, take, ee;
  logic [1:0] cause;
  logic [31:0] vec_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_halt_ctrl u_irq_halt_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ee_wr(ee_wr), .ee_wdata(ee_wdata),
    .vsel(vsel), .xlate_on(xlate_on), .ff_valid(ff_valid), .ff_miss(ff_miss),
    .ff_dseg(ff_dseg), .ff_noexec(ff_noexec), .ff_guard(ff_guard), .ff_prot(ff_prot),
    .cmpl_valid(cmpl_valid), .stq_empty(stq_empty), .cmpl_block(cmpl_block),
    .take(take), .cause(cause), .vec_addr(vec_addr), .ee(ee)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 one-retire window, 2 draining, 3 taking
  int m_phase = 0;
  int m_why = 0;
  bit m_en = 0;

  always @(posedge clk) begin
    bit bad;
    int np;
    int nw;
    bad = ff_valid && (ff_miss || ff_noexec || ff_prot || (xlate_on && (ff_dseg || ff_guard)));
    np = m_phase;
    nw = m_why;
    if (!rst_n) begin
      m_phase = 0; m_why = 0; m_en = 0;
    end else begin
      if (m_phase == 3) np = 0;
      else if (bad) begin np = 3; nw = 1; end
      else if (m_phase == 0 && irq_req && m_en) np = 1;
      else if (m_phase == 1 && cmpl_valid) np = 2;
      else if (m_phase == 2 && stq_empty) begin np = 3; nw = 2; end
      if (m_phase == 3) m_en = 0;
      else if (ee_wr) m_en = ee_wdata;
      m_phase = np;
      m_why = nw;
    end
  end

  always @(negedge clk) begin
    logic [31:0] ev;
    #2;
    if (rst_n && !done) begin
      ev = (m_phase == 3) ? ((vsel ? 32'hFFF0_0000 : 32'h0) + ((m_why == 2) ? 32'h500 : 32'h400)) : 32'h0;
      chk(cmpl_block == (m_phase >= 2), "R4 model cmpl_block", {31'b0, cmpl_block}, {31'b0, m_phase >= 2});
      chk(take == (m_phase == 3), "R9 model take", {31'b0, take}, {31'b0, m_phase == 3});
      chk(cause == ((m_phase == 3) ? m_why[1:0] : 2'b00), "R9 model cause", {30'b0, cause},
          {30'b0, (m_phase == 3) ? m_why[1:0] : 2'b00});
      chk(vec_addr == ev, "R7 model vec_addr", vec_addr, ev);
      chk(ee == m_en, "R10 model ee", {31'b0, ee}, {31'b0, m_en});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 20000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(); @(negedge clk); #3; endtask
  task automatic set_en(input logic v); ee_wr = 1; ee_wdata = v; cyc(); ee_wr = 0; endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk(!take && !cmpl_block && !ee && cause == 0 && vec_addr == 0, "R10 reset state",
        {27'b0, take, cmpl_block, ee, cause}, 32'h0);

    // R1: request ignored while disabled
    irq_req = 1;
    repeat (4) begin cyc(); chk(!cmpl_block && !take, "R1 disabled irq", {30'b0, cmpl_block, take}, 0); end
    irq_req = 0;

    // R3 R4 R5: full halt-and-drain
    set_en(1);
    chk(ee, "R10 software set", {31'b0, ee}, 1);
    irq_req = 1; cyc();
    chk(!cmpl_block, "R3 window open", {31'b0, cmpl_block}, 0);
    cyc(); cyc();
    chk(!cmpl_block && !take, "R3 waits for one retire", {30'b0, cmpl_block, take}, 0);
    cmpl_valid = 1; cyc(); cmpl_valid = 0;
    chk(cmpl_block, "R3 blocked after one retire", {31'b0, cmpl_block}, 1);
    repeat (3) begin cyc(); chk(cmpl_block && !take, "R5 waiting for stores", {30'b0, cmpl_block, take}, 32'h2); end
    stq_empty = 1; cyc();
    chk(take && cause == 2'b10 && vec_addr == 32'h500 && cmpl_block, "R7 ext take low base",
        vec_addr, 32'h500);
    irq_req = 0; cyc();
    chk(!take && !ee && !cmpl_block, "R10 ee cleared by take", {30'b0, take, ee}, 0);

    // R7 high base
    set_en(1); vsel = 1; irq_req = 1; cyc();
    cmpl_valid = 1; cyc(); cmpl_valid = 0; cyc();
    chk(take && vec_addr == 32'hFFF0_0500, "R7 ext take high base", vec_addr, 32'hFFF0_0500);
    irq_req = 0; cyc(); vsel = 0;

    // R2: simultaneous fault and interrupt
    set_en(1); irq_req = 1; ff_valid = 1; ff_miss = 1; cyc(); ff_valid = 0; ff_miss = 0;
    chk(take && cause == 2'b01 && vec_addr == 32'h400, "R2 fault wins", {30'b0, cause}, 32'h1);
    cyc(); cyc();
    chk(!cmpl_block && !take && !ee, "R2 irq not accepted", {29'b0, cmpl_block, take, ee}, 0);

    // R6: preempt during drain, then re-accept
    stq_empty = 0; set_en(1); cyc();
    cmpl_valid = 1; cyc(); cmpl_valid = 0;
    ff_valid = 1; ff_prot = 1; cyc(); ff_valid = 0; ff_prot = 0;
    chk(take && cause == 2'b01, "R6 drain preempted", {30'b0, cause}, 32'h1);
    cyc(); cyc();
    chk(!cmpl_block && !take, "R6 waits for enable", {30'b0, cmpl_block, take}, 0);
    set_en(1); cyc();
    chk(!cmpl_block, "R6 re-accepted window", {31'b0, cmpl_block}, 0);
    cmpl_valid = 1; stq_empty = 1; cyc(); cmpl_valid = 0; cyc();
    chk(take && cause == 2'b10, "R6 ext after preempt", {30'b0, cause}, 32'h2);
    cyc();

    // R6: preempt in the one-retire window
    set_en(1); cyc();
    ff_valid = 1; ff_noexec = 1; cyc(); ff_valid = 0; ff_noexec = 0;
    chk(take && cause == 2'b01, "R6 window preempted", {30'b0, cause}, 32'h1);
    irq_req = 0; cyc();

    // R8: decode
    xlate_on = 0; ff_valid = 1; ff_dseg = 1; cyc();
    chk(!take, "R8 dseg no xlate", {31'b0, take}, 0);
    ff_dseg = 0; ff_guard = 1; cyc();
    chk(!take, "R8 guard no xlate", {31'b0, take}, 0);
    ff_guard = 0; ff_valid = 0; cyc();
    xlate_on = 1; ff_valid = 1; ff_guard = 1; cyc(); ff_valid = 0; ff_guard = 0;
    chk(take && cause == 2'b01, "R8 guard xlate", {31'b0, take}, 1);
    cyc();
    ff_valid = 1; ff_dseg = 1; cyc(); ff_valid = 0; ff_dseg = 0;
    chk(take, "R8 dseg xlate", {31'b0, take}, 1);
    cyc();
    ff_miss = 1; cyc();
    chk(!take, "R8 no valid no fault", {31'b0, take}, 0);
    ff_miss = 0;

    // R10: clear wins over write
    ff_valid = 1; ff_miss = 1; cyc(); ff_valid = 0; ff_miss = 0;
    ee_wr = 1; ee_wdata = 1; cyc(); ee_wr = 0;
    chk(!ee, "R10 clear wins", {31'b0, ee}, 0);
    set_en(1); set_en(0);
    chk(!ee, "R10 software clear", {31'b0, ee}, 0);
    cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule